// File: doc/BRIEF.md
# Multi-Queue Transmit Channel Scheduler

This block decides which transmit descriptor queue feeds each outbound DMA/FIFO channel. It holds sixteen circular queues, each described by an 8-bit host-owned write index, an 8-bit read index that the scheduler moves forward, an empty flag and a 10-bit configuration word. The configuration word turns the queue on, picks the single channel the queue feeds, and stores a window-left bit and an acknowledgement-mode bit. Any number of queues may share one channel.

Software programs the block through a one-cycle register write port. A separate combinational read port shows every register. The configuration word and the empty-flag register both carry their own per-bit write masks in their upper bits, so a single write can change one field and leave its neighbours alone.

Each of the eight channels has a request/ready handshake. A channel raises its request, and names a queue, whenever it is enabled and at least one active, non-empty queue is mapped to it. The cycle in which the channel's ready is also high completes a transfer. In that cycle the named queue's read index moves forward by one, and the rotation for that channel moves past that queue.

Top module: `txq_sched`

## Requirements
- R1: After reset every index is 0, every configuration word is 0, all sixteen empty flags read 1, the channel-enable register reads 0 and no channel requests.
- R2: A write to a queue's configuration word (address 0x10+q) updates bit i (i = 0..9) only when data bit 10+i is 1. Bit 0 is active, bits 4:1 the channel number, bit 5 window-left and bit 8 acknowledgement mode. A read returns the 10 bits in positions 9:0.
- R3: The channel-enable register (address 0x00, bit c for channel c) gates requests. A channel whose bit is 0 never requests, even if eligible queues exist.
- R4: Writing a write index (0x20+q) or a read index (0x30+q) stores the low 8 data bits. Every index change sets that queue's empty flag to (read index == write index).
- R5: A write to the empty-flag register (address 0x01) sets empty flag q to data bit q only where data bit 16+q is 1. The other flags keep their values. A read returns the flags in bits 15:0.
- R6: Channel c requests when it is enabled and some queue is active, not empty and has channel field c. The queue it names satisfies all three conditions.
- R7: Among eligible queues on one channel, the named queue is the first one in increasing queue number, wrapping at 16, that comes after the queue last granted on that channel. Queue 0 counts as last granted after reset.
- R8: When a channel's request and ready are both high at a clock edge, the named queue's read index becomes its old value plus one, modulo 256, at that edge.
- R9: Changing a queue's channel field moves the queue to the new channel. It is then named only by the new channel.
- R10: A queue whose active bit is 0 is never named by any channel, whatever its indexes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Write address: bits 5:4 select group, bits 3:0 queue or register |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 6 | Read address, same map as writes |
| cfg_rdata | output | 32 | Read data, combinational |
| ch_ready | input | 8 | Per-channel ready; with request completes a transfer |
| ch_req | output | 8 | Per-channel request |
| ch_qid | output | 32 | Per-channel named queue, 4 bits per channel, channel c at bits 4c+3:4c |

## Verification
If a read index is wrong, the error shows on the read port in the cycle after the handshake. It also shows as a request that stays up or drops one transfer too early. If an empty flag is wrong, the channel's request turns on or off in the same cycle, so the bench compares the request line after every index write and every transfer. If the rotation pointer is wrong, the next queue named on that channel is wrong, and the scoreboard catches it at the very next handshake. A write mask that leaks shows up as a changed field on the read port right after the partial write.

// File: rtl/txq_sched.sv
module txq_sched #(
  parameter int NQ  = 16,
  parameter int NCH = 8,
  parameter int PW  = 8,
  parameter int DW  = 32,
  localparam int QW = $clog2(NQ),
  localparam int AW = QW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [AW-1:0]     cfg_raddr,
  output logic [DW-1:0]     cfg_rdata,
  input  logic [NCH-1:0]    ch_ready,
  output logic [NCH-1:0]    ch_req,
  output logic [NCH*QW-1:0] ch_qid
);
  localparam int SW = 10;

  logic [SW-1:0] stat_q [NQ];
  logic [PW-1:0] wp_q   [NQ];
  logic [PW-1:0] rp_q   [NQ];
  logic [NQ-1:0] empty_q;
  logic [NCH-1:0] chen_q;
  logic [QW-1:0] last_q [NCH];

  logic [1:0]    wsel;
  logic [QW-1:0] wq;
  assign wsel = cfg_addr[AW-1:AW-2];
  assign wq   = cfg_addr[QW-1:0];

  logic wr_ctl, wr_stat, wr_wp, wr_rp, wr_chen, wr_emp;
  assign wr_ctl  = cfg_we && wsel == 2'd0;
  assign wr_stat = cfg_we && wsel == 2'd1;
  assign wr_wp   = cfg_we && wsel == 2'd2;
  assign wr_rp   = cfg_we && wsel == 2'd3;
  assign wr_chen = wr_ctl && wq == QW'(0);
  assign wr_emp  = wr_ctl && wq == QW'(1);

  logic [NQ-1:0] elig;
  always_comb
    for (int q = 0; q < NQ; q++) elig[q] = stat_q[q][0] & ~empty_q[q];

  logic [NCH-1:0] pick_v;
  logic [QW-1:0]  pick_q [NCH];
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      pick_v[c] = 1'b0;
      pick_q[c] = '0;
      for (int k = 1; k <= NQ; k++) begin
        logic [QW-1:0] idx;
        idx = last_q[c] + QW'(k);
        if (!pick_v[c] && elig[idx] && stat_q[idx][4:1] == 4'(c)) begin
          pick_v[c] = 1'b1;
          pick_q[c] = idx;
        end
      end
    end
  end

  logic [NCH-1:0] fire;
  assign ch_req = chen_q & pick_v;
  assign fire   = ch_req & ch_ready;

  always_comb
    for (int c = 0; c < NCH; c++) ch_qid[c*QW +: QW] = pick_q[c];

  logic [NQ-1:0] adv, hrp, hwp, pchg;
  logic [PW-1:0] rp_n [NQ];
  logic [PW-1:0] wp_n [NQ];
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      adv[q] = 1'b0;
      for (int c = 0; c < NCH; c++)
        if (fire[c] && pick_q[c] == QW'(q)) adv[q] = 1'b1;
      hrp[q]  = wr_rp && wq == QW'(q);
      hwp[q]  = wr_wp && wq == QW'(q);
      rp_n[q] = hrp[q] ? cfg_wdata[PW-1:0] : (adv[q] ? rp_q[q] + PW'(1) : rp_q[q]);
      wp_n[q] = hwp[q] ? cfg_wdata[PW-1:0] : wp_q[q];
      pchg[q] = adv[q] | hrp[q] | hwp[q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= '1;
      chen_q  <= '0;
      for (int q = 0; q < NQ; q++) begin
        stat_q[q] <= '0;
        wp_q[q]   <= '0;
        rp_q[q]   <= '0;
      end
      for (int c = 0; c < NCH; c++) last_q[c] <= '0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (fire[c]) last_q[c] <= pick_q[c];
      for (int q = 0; q < NQ; q++) begin
        rp_q[q] <= rp_n[q];
        wp_q[q] <= wp_n[q];
        if (wr_emp && cfg_wdata[16+q]) empty_q[q] <= cfg_wdata[q];
        else if (pchg[q])              empty_q[q] <= (rp_n[q] == wp_n[q]);
      end
      if (wr_chen) chen_q <= cfg_wdata[NCH-1:0];
      if (wr_stat)
        for (int i = 0; i < SW; i++)
          if (cfg_wdata[SW+i]) stat_q[wq][i] <= cfg_wdata[i];
    end
  end

  logic [1:0]    rsel;
  logic [QW-1:0] rq;
  assign rsel = cfg_raddr[AW-1:AW-2];
  assign rq   = cfg_raddr[QW-1:0];

  always_comb begin
    cfg_rdata = '0;
    case (rsel)
      2'd0: begin
        if (rq == QW'(0))      cfg_rdata[NCH-1:0] = chen_q;
        else if (rq == QW'(1)) cfg_rdata[NQ-1:0]  = empty_q;
      end
      2'd1:    cfg_rdata[SW-1:0] = stat_q[rq];
      2'd2:    cfg_rdata[PW-1:0] = wp_q[rq];
      default: cfg_rdata[PW-1:0] = rp_q[rq];
    endcase
  end

  for (genvar q = 0; q < NQ; q++) begin : g_qchk
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv[q] && !hrp[q]) |=> rp_q[q] == $past(rp_q[q]) + PW'(1)); // R8
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv[q] && !hrp[q]) |=> $stable(rp_q[q])); // R8
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stat && wq == QW'(q)) |=> $stable(stat_q[q])); // R2
    AST_EMPTY_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (pchg[q] && !(wr_emp && cfg_wdata[16+q])) |=> empty_q[q] == (rp_q[q] == wp_q[q])); // R4
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cchk
    AST_REQ_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      ch_req[c] |-> (chen_q[c] && stat_q[pick_q[c]][0] && !empty_q[pick_q[c]]
                     && stat_q[pick_q[c]][4:1] == 4'(c))); // R6
  end
endmodule

// File: tb/txq_sched_tb.sv
`timescale 1ns/1ps
module txq_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  ch_ready = '0;
  logic [7:0]  ch_req;
  logic [31:0] ch_qid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  txq_sched u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .ch_ready(ch_ready), .ch_req(ch_req), .ch_qid(ch_qid));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input int exp, input string tag);
    cfg_raddr = a; #1;
    check(cfg_rdata == 32'(exp), tag, cfg_rdata, exp);
  endtask

  task automatic req_chk(input int c, input bit v, input int q, input string tag);
    #1;
    check(ch_req[c] == v, {tag, " req"}, ch_req[c], v);
    if (v) check(ch_qid[c*4 +: 4] == 4'(q), {tag, " qid"}, ch_qid[c*4 +: 4], q);
  endtask

  task automatic grant(input int c, input int q);
    exp_q.push_back({4'(c), 4'(q)});
    @(posedge clk); #1;
    ch_ready[c] = 1'b1;
    @(posedge clk); #1;
    ch_ready[c] = 1'b0;
  endtask

  always @(negedge clk) begin
    for (int c = 0; c < 8; c++) begin
      if (ch_ready[c]) begin
        if (!ch_req[c]) begin
          check(1'b0, "R6 handshake without request", c, 1);
        end else if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected grant", c, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(e[7:4] == 4'(c) && e[3:0] == ch_qid[c*4 +: 4], "R7 scoreboard grant",
                {c[3:0], ch_qid[c*4 +: 4]}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd_chk(6'h00, 0, "R1 chan enable");
    rd_chk(6'h01, 32'hFFFF, "R1 empty flags");
    rd_chk(6'h33, 0, "R1 read index");
    rd_chk(6'h13, 0, "R1 status");
    check(ch_req == 8'h00, "R1 no request", ch_req, 0);

    // R2 masked status writes
    wr(6'h13, 32'hFFC05);
    rd_chk(6'h13, 32'h005, "R2 full write");
    wr(6'h13, 32'h401FE);
    rd_chk(6'h13, 32'h105, "R2 partial write");

    // R4 / R3
    wr(6'h23, 32'd2);
    rd_chk(6'h01, 32'hFFF7, "R4 empty cleared");
    req_chk(2, 1'b0, 0, "R3 disabled channel");
    wr(6'h00, 32'h04);
    req_chk(2, 1'b1, 3, "R6 request on enable");

    // R8 advance
    grant(2, 3);
    rd_chk(6'h33, 1, "R8 step one");
    grant(2, 3);
    rd_chk(6'h33, 2, "R8 step two");
    rd_chk(6'h01, 32'hFFFF, "R4 empty after drain");
    req_chk(2, 1'b0, 0, "R4 drained channel idle");

    // R7 rotation on channel 1
    wr(6'h11, 32'hFFC03);
    wr(6'h15, 32'hFFC03);
    wr(6'h19, 32'hFFC03);
    wr(6'h21, 32'd4);
    wr(6'h25, 32'd4);
    wr(6'h29, 32'd4);
    wr(6'h00, 32'h06);
    req_chk(1, 1'b1, 1, "R7 first after reset");
    grant(1, 1);
    req_chk(1, 1'b1, 5, "R7 next after 1");
    grant(1, 5);
    grant(1, 9);
    req_chk(1, 1'b1, 1, "R7 wrap to 1");
    grant(1, 1);
    rd_chk(6'h31, 2, "R8 q1 index");
    rd_chk(6'h39, 1, "R8 q9 index");

    // R8 modulo wrap
    wr(6'h17, 32'hFFC01);
    wr(6'h37, 32'd255);
    wr(6'h27, 32'd1);
    wr(6'h00, 32'h07);
    req_chk(0, 1'b1, 7, "R6 channel 0 q7");
    grant(0, 7);
    rd_chk(6'h37, 0, "R8 wrap 255 to 0");
    grant(0, 7);
    rd_chk(6'h37, 1, "R8 after wrap");
    req_chk(0, 1'b0, 0, "R4 q7 drained");

    // R5 masked empty write
    wr(6'h01, 32'h0002_0002);
    rd_chk(6'h01, 32'hFDDF, "R5 masked empty");
    req_chk(1, 1'b1, 5, "R5 forced-empty queue skipped");

    // R10 inactive
    wr(6'h15, 32'h00400);
    rd_chk(6'h15, 32'h002, "R10 status after clear");
    req_chk(1, 1'b1, 9, "R10 inactive skipped");

    // R9 channel move
    wr(6'h19, 32'h07806);
    rd_chk(6'h19, 32'h007, "R9 status moved");
    req_chk(1, 1'b0, 0, "R9 old channel idle");
    wr(6'h00, 32'h0E);
    req_chk(3, 1'b1, 9, "R9 new channel");
    grant(3, 9);
    rd_chk(6'h39, 2, "R9 grant on new channel");

    // R4 index write recomputes forced flag
    wr(6'h21, 32'd4);
    req_chk(1, 1'b1, 1, "R4 recompute after write");

    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule